// File: doc/BRIEF.md
# Serial Management Target with Preamble Suppression

This block is the device-side end of a two-wire serial management bus. It is clocked directly by the management clock, samples the shared data line on each rising edge, and parses the frame: start pattern, operation code, a 5-bit device address, a 5-bit register address, two turnaround bits and sixteen data bits. A frame whose device address equals the strap input `phyAddr` is served: a write stores the data into a small register bank, and a read drives the turnaround and the register contents back through an output value and an output enable that feed an external tri-state pad.

After a hardware reset, or after software sets the self-clearing reset bit in the control register, the block answers nothing until it has seen an unbroken run of preamble ones. From then on it accepts frames back to back, with only a single idle one between them. The status register advertises this with a fixed one in its suppression bit. Besides the control and status registers, the bank holds a few plain read/write scratch registers.

Top module: `mdioTarget`

## Requirements
- R1: After reset `mdioOe` is 0 and `mdioOut` is 1, and no frame gets a response until the preamble condition of R2 is met.
- R2: Only after at least 32 consecutive ones on the line (PREAMBLE_LEN) does the block respond. A 0 restarts the count, so a run of 31 ones followed by a frame leaves the frame unanswered.
- R3: A read uses start 01 and opcode 10, with both address fields sent MSB first. The line stays released while the first turnaround bit is on the bus. `mdioOe` goes to 1 with `mdioOut` 0 on the rising edge that samples the first turnaround bit. Each following rising edge launches one data bit, MSB first. `mdioOe` returns to 0 on the rising edge that samples the last data bit, so 17 bit times are driven in all.
- R4: A write uses start 01 and opcode 01, then turnaround 10 and sixteen data bits sent MSB first. It stores the data in the addressed register, and a later read returns that value.
- R5: Once preamble has been seen, a frame that follows the previous one after a single idle one is accepted, with no new preamble.
- R6: A frame whose device address differs from `phyAddr` is parsed but ignored. `mdioOe` stays 0 and no register changes.
- R7: A 0 in place of the second start bit, or an opcode of 00 or 11, abandons the frame. No register changes and the line is not driven, and the next properly idled frame is served.
- R8: Register 1 is read-only and reads STATUS_VALUE, with bit 6 (preamble suppression supported) forced to 1. Writes to it have no effect.
- R9: Register 0 resets to CTRL_RESET (0x3100). Writing it stores bits 14..0, and bit 15 always reads 0. Writing a 1 to bit 15 returns all registers to their reset values, and a new preamble is then required before the block responds again.
- R10: Registers 2..NUM_REGS-1 reset to 0 and are read/write. Addresses at or above NUM_REGS read as 0, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| phyAddr | input | 5 | Strapped device address to match |
| mdioIn | input | 1 | Sampled value of the shared data line |
| mdioOut | output | 1 | Value to drive onto the data line when enabled |
| mdioOe | output | 1 | Output enable for the data line pad; 0 releases the line |

## Verification
Counting the first start bit as bit 0, the bench drives bit k during the low phase before rising edge k and samples the outputs 1 ns after the falling edge. A value seen in window k therefore reflects rising edge k-1. So `mdioOe` must still be 0 in window 14 and must be 1 with `mdioOut` 0 in window 15. Data bit 15-j is expected in window 16+j, and the enable must be 0 again in window 32, the idle bit. A write takes effect on rising edge 31, so its result is read back in the very next frame after one idle bit. Ignored frames are checked by watching the enable over the whole frame and then reading the register they might have changed.

// File: rtl/mdioPkg.sv
package mdioPkg;

  typedef enum logic [3:0] {
    sPreamble,
    sGap,
    sHunt,
    sStart2,
    sOp1,
    sOp2,
    sPhy,
    sReg,
    sTa1,
    sTa2,
    sData
  } mdioState_t;

  // Strobes from control to datapath, valid for the current rising edge.
  typedef struct packed {
    logic shiftIn;
    logic capReg;
    logic loadRd;
    logic driveTa;
    logic driveBit;
    logic relOe;
    logic commitWr;
  } mdioStrobe_t;

endpackage

// File: rtl/mdioCtrl.sv
module mdioCtrl
  import mdioPkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 5,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        mdc,
  input  logic        rstN,
  input  logic        mdioIn,
  input  logic        phyHit,
  input  logic        softRst,
  output mdioStrobe_t strobe,
  output mdioState_t  stateOut
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam int PRE_W = $clog2(PREAMBLE_LEN);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
  localparam logic [PRE_W-1:0] LAST_PRE  = PRE_W'(PREAMBLE_LEN - 1);

  mdioState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic [PRE_W-1:0] preCnt;
  logic             opRead;
  logic             opFirst;
  logic             hit;
  logic             readHit;
  logic             writeHit;
  logic             lastData;

  assign stateOut = state;
  assign readHit  = opRead && hit;
  assign writeHit = !opRead && hit;
  assign lastData = (bitCnt == LAST_DATA);

  always_comb begin
    strobe          = '0;
    strobe.shiftIn  = (state == sPhy) || (state == sReg) ||
                      ((state == sData) && writeHit);
    strobe.capReg   = (state == sReg) && (bitCnt == LAST_ADDR);
    strobe.loadRd   = (state == sTa1) && readHit;
    strobe.driveTa  = (state == sTa1) && readHit;
    strobe.driveBit = ((state == sTa2) && readHit) ||
                      ((state == sData) && readHit && !lastData);
    strobe.relOe    = (state == sData) && readHit && lastData;
    strobe.commitWr = (state == sData) && writeHit && lastData;
  end

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      state   <= sPreamble;
      bitCnt  <= '0;
      preCnt  <= '0;
      opRead  <= 1'b0;
      opFirst <= 1'b0;
      hit     <= 1'b0;
    end else if (softRst) begin
      state  <= sPreamble;
      bitCnt <= '0;
      preCnt <= '0;
    end else begin
      case (state)
        sPreamble: begin
          if (!mdioIn) begin
            preCnt <= '0;
          end else if (preCnt == LAST_PRE) begin
            preCnt <= '0;
            state  <= sHunt;
          end else begin
            preCnt <= preCnt + 1'b1;
          end
        end
        sGap:    if (mdioIn) state <= sHunt;
        sHunt:   if (!mdioIn) state <= sStart2;
        sStart2: state <= mdioIn ? sOp1 : sGap;
        sOp1: begin
          opFirst <= mdioIn;
          state   <= sOp2;
        end
        sOp2: begin
          if (opFirst != mdioIn) begin
            opRead <= opFirst;
            bitCnt <= '0;
            state  <= sPhy;
          end else begin
            state <= sGap;
          end
        end
        sPhy: begin
          if (bitCnt == LAST_ADDR) begin
            hit    <= phyHit;
            bitCnt <= '0;
            state  <= sReg;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        sReg: begin
          if (bitCnt == LAST_ADDR) begin
            bitCnt <= '0;
            state  <= sTa1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        sTa1: state <= sTa2;
        sTa2: begin
          bitCnt <= '0;
          state  <= sData;
        end
        sData: begin
          if (lastData) begin
            bitCnt <= '0;
            state  <= sGap;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= sGap;
      endcase
    end
  end

  // R7: a broken start pattern falls back to waiting for an idle one
  a_r7_bad_start_to_gap: assert property (@(posedge mdc) disable iff (!rstN)
    (state == sStart2 && !mdioIn && !softRst) |=> (state == sGap));

endmodule

// File: rtl/mdioDatapath.sv
module mdioDatapath
  import mdioPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic              mdioIn,
  input  mdioStrobe_t       strobe,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              phyHit,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              mdioOut,
  output logic              mdioOe
);

  localparam int OEC_W = $clog2(DATA_W + 2) + 1;

  logic [DATA_W-1:0] shiftQ;
  logic [ADDR_W-1:0] regAddrQ;
  logic              outQ;
  logic              oeQ;

  assign phyHit  = ({shiftQ[ADDR_W-2:0], mdioIn} == phyAddr);
  assign wrData  = {shiftQ[DATA_W-2:0], mdioIn};
  assign regAddr = regAddrQ;
  assign mdioOut = outQ;
  assign mdioOe  = oeQ;

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      shiftQ   <= '0;
      regAddrQ <= '0;
    end else begin
      if (strobe.loadRd) begin
        shiftQ <= rdData;
      end else if (strobe.shiftIn) begin
        shiftQ <= {shiftQ[DATA_W-2:0], mdioIn};
      end else if (strobe.driveBit) begin
        shiftQ <= {shiftQ[DATA_W-2:0], 1'b0};
      end
      if (strobe.capReg) begin
        regAddrQ <= {shiftQ[ADDR_W-2:0], mdioIn};
      end
    end
  end

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      outQ <= 1'b1;
      oeQ  <= 1'b0;
    end else if (strobe.driveTa) begin
      outQ <= 1'b0;
      oeQ  <= 1'b1;
    end else if (strobe.driveBit) begin
      outQ <= shiftQ[DATA_W-1];
    end else if (strobe.relOe) begin
      outQ <= 1'b1;
      oeQ  <= 1'b0;
    end
  end

  // Checker: counts consecutive driven bit times
  logic [OEC_W-1:0] oeCnt;
  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) oeCnt <= '0;
    else if (!oeQ) oeCnt <= '0;
    else oeCnt <= oeCnt + 1'b1;
  end

  // R3: the first driven bit is the turnaround zero
  a_r3_ta_zero: assert property (@(posedge mdc) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut);

  // R3: turnaround plus sixteen data bits are driven
  a_r3_drive_len: assert property (@(posedge mdc) disable iff (!rstN)
    $fell(mdioOe) |-> (oeCnt == OEC_W'(DATA_W + 1)));

endmodule

// File: rtl/mdioRegBank.sv
module mdioRegBank #(
  parameter int              DATA_W       = 16,
  parameter int              ADDR_W       = 5,
  parameter int              NUM_REGS     = 8,
  parameter int              SOFT_RST_BIT = 15,
  parameter int              SUPPRESS_BIT = 6,
  parameter logic [15:0]     CTRL_RESET   = 16'h3100,
  parameter logic [15:0]     STATUS_VALUE = 16'h7849
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              softRst
);

  localparam int                NUM_SCRATCH = NUM_REGS - 2;
  localparam logic [DATA_W-1:0] SR_MASK     = DATA_W'(1) << SOFT_RST_BIT;
  localparam logic [DATA_W-1:0] SUP_MASK    = DATA_W'(1) << SUPPRESS_BIT;
  localparam logic [DATA_W-1:0] CTRL_INIT   = DATA_W'(CTRL_RESET) & ~SR_MASK;
  localparam logic [DATA_W-1:0] STATUS_RD   = DATA_W'(STATUS_VALUE) | SUP_MASK;

  logic [DATA_W-1:0] ctrlQ;
  logic [DATA_W-1:0] scratchFlat [NUM_SCRATCH];

  assign softRst = wrEn && (addr == '0) && wrData[SOFT_RST_BIT];

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) ctrlQ <= CTRL_INIT;
    else if (softRst) ctrlQ <= CTRL_INIT;
    else if (wrEn && addr == '0) ctrlQ <= wrData & ~SR_MASK;
  end

  for (genvar g = 0; g < NUM_SCRATCH; g++) begin : gScratch
    logic [DATA_W-1:0] q;
    always_ff @(posedge mdc or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (softRst) q <= '0;
      else if (wrEn && addr == ADDR_W'(g + 2)) q <= wrData;
    end
    assign scratchFlat[g] = q;
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(0)) rdData = ctrlQ;
    if (addr == ADDR_W'(1)) rdData = STATUS_RD;
    for (int i = 0; i < NUM_SCRATCH; i++) begin
      if (addr == ADDR_W'(i + 2)) rdData = scratchFlat[i];
    end
  end

  // R4: a scratch write is visible at the next edge
  a_r4_write_lands: assert property (@(posedge mdc) disable iff (!rstN)
    (wrEn && addr >= ADDR_W'(2) && addr < ADDR_W'(NUM_REGS)) |=>
      (rdData == $past(wrData)));

  // R8: status always advertises suppression support
  a_r8_status_advert: assert property (@(posedge mdc) disable iff (!rstN)
    (addr == ADDR_W'(1)) |-> rdData[SUPPRESS_BIT]);

endmodule

// File: rtl/mdioTarget.sv
module mdioTarget
  import mdioPkg::*;
#(
  parameter int          DATA_W       = 16,
  parameter int          ADDR_W       = 5,
  parameter int          NUM_REGS     = 8,
  parameter int          PREAMBLE_LEN = 32,
  parameter logic [15:0] CTRL_RESET   = 16'h3100,
  parameter logic [15:0] STATUS_VALUE = 16'h7849
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe
);

  mdioStrobe_t       strobe;
  mdioState_t        ctrlState;
  logic              phyHit;
  logic              softRst;
  logic [ADDR_W-1:0] regAddr;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdData;

  mdioCtrl #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .PREAMBLE_LEN(PREAMBLE_LEN)
  ) i_ctrl (
    .mdc     (mdc),
    .rstN    (rstN),
    .mdioIn  (mdioIn),
    .phyHit  (phyHit),
    .softRst (softRst),
    .strobe  (strobe),
    .stateOut(ctrlState)
  );

  mdioDatapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) i_datapath (
    .mdc    (mdc),
    .rstN   (rstN),
    .mdioIn (mdioIn),
    .strobe (strobe),
    .phyAddr(phyAddr),
    .rdData (rdData),
    .phyHit (phyHit),
    .regAddr(regAddr),
    .wrData (wrData),
    .mdioOut(mdioOut),
    .mdioOe (mdioOe)
  );

  mdioRegBank #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .NUM_REGS    (NUM_REGS),
    .CTRL_RESET  (CTRL_RESET),
    .STATUS_VALUE(STATUS_VALUE)
  ) i_regBank (
    .mdc    (mdc),
    .rstN   (rstN),
    .wrEn   (strobe.commitWr),
    .addr   (regAddr),
    .wrData (wrData),
    .rdData (rdData),
    .softRst(softRst)
  );

  // R1: nothing is driven while waiting for the initial preamble
  a_r1_quiet_before_init: assert property (@(posedge mdc) disable iff (!rstN)
    (ctrlState == sPreamble) |-> !mdioOe);

endmodule

// File: tb/test_mdioTarget.sv
`timescale 1ns/1ps
module test_mdioTarget;

  localparam logic [4:0] MY_PHY = 5'h0C;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stDrive = 1'b1;
  logic       dutOut;
  logic       dutOe;
  logic       mdioLine;
  int         nCmp = 0;
  int         nBad = 0;
  bit         done = 1'b0;
  logic [15:0] model [0:7];

  always #2 clk = ~clk;

  assign mdioLine = dutOe ? dutOut : stDrive;

  mdioTarget i_mdioTarget (
    .mdc    (clk),
    .rstN   (rstN),
    .phyAddr(MY_PHY),
    .mdioIn (mdioLine),
    .mdioOut(dutOut),
    .mdioOe (dutOe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic resetModel();
    model[0] = 16'h3100;
    model[1] = 16'h7849;
    for (int i = 2; i < 8; i++) model[i] = 16'h0000;
  endtask

  function automatic logic [15:0] expRead(input logic [4:0] a);
    if (a < 5'd8) return model[a[2:0]];
    return 16'h0000;
  endfunction

  task automatic modelWrite(input logic [4:0] a, input logic [15:0] d);
    if (a == 5'd0) begin
      if (d[15]) resetModel();
      else model[0] = d & 16'h7FFF;
    end else if (a >= 5'd2 && a < 5'd8) begin
      model[a[2:0]] = d;
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    stDrive = b;
  endtask

  task automatic sendOnes(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
  endtask

  task automatic doWrite(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    logic [31:0] fr;
    fr = {2'b01, 2'b01, phy, ra, 2'b10, d};
    for (int i = 31; i >= 0; i--) sendBit(fr[i]);
    sendBit(1'b1);
  endtask

  // Returns read word, whether drive timing was right, and whether anything drove
  task automatic doRead(input logic [4:0] phy, input logic [4:0] ra,
                        output logic [15:0] word, output logic taOk, output logic anyDrv);
    logic [31:0] fr;
    logic oeS [0:32];
    logic outS [0:32];
    fr = {2'b01, 2'b10, phy, ra, 18'h3FFFF};
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      stDrive = (k < 14) ? fr[31-k] : 1'b1;
      #1;
      oeS[k]  = dutOe;
      outS[k] = dutOut;
    end
    @(negedge clk);
    stDrive = 1'b1;
    #1;
    oeS[32]  = dutOe;
    outS[32] = dutOut;
    word   = '0;
    anyDrv = 1'b0;
    for (int j = 0; j < 16; j++) word[15-j] = outS[16+j];
    for (int k = 0; k < 33; k++) anyDrv = anyDrv | oeS[k];
    taOk = !oeS[14] && oeS[15] && !outS[15] && !oeS[32];
    for (int k = 16; k < 32; k++) taOk = taOk & oeS[k];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic ok;
    logic drv;
    void'($urandom(32'd4711));
    resetModel();
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset oe", {31'd0, dutOe}, 32'd0);
    check("R1 reset out", {31'd0, dutOut}, 32'd1);
    rstN = 1'b1;

    // R1: no preamble yet, no response
    doRead(MY_PHY, 5'd1, w, ok, drv);
    check("R1 no drive before preamble", {31'd0, drv}, 32'd0);

    // R2: 31 ones are not enough
    sendBit(1'b0);
    sendOnes(31);
    doRead(MY_PHY, 5'd1, w, ok, drv);
    check("R2 31 ones no drive", {31'd0, drv}, 32'd0);

    // R2: 32 ones initialize; R8 status value
    sendBit(1'b0);
    sendOnes(32);
    doRead(MY_PHY, 5'd1, w, ok, drv);
    check("R2 response after 32 ones", {31'd0, drv}, 32'd1);
    check("R3 turnaround timing", {31'd0, ok}, 32'd1);
    check("R8 status value", {16'd0, w}, {16'd0, expRead(5'd1)});
    check("R8 suppression bit", {31'd0, w[6]}, 32'd1);

    // R4, R5: write then read with single idle bits
    doWrite(MY_PHY, 5'd3, 16'hA5C3);
    modelWrite(5'd3, 16'hA5C3);
    doRead(MY_PHY, 5'd3, w, ok, drv);
    check("R4 R5 scratch readback", {16'd0, w}, {16'd0, expRead(5'd3)});
    check("R3 timing back-to-back", {31'd0, ok}, 32'd1);
    doRead(MY_PHY, 5'd0, w, ok, drv);
    check("R9 control reset value", {16'd0, w}, 32'h0000_3100);

    // R8: status ignores writes
    doWrite(MY_PHY, 5'd1, 16'h0000);
    doRead(MY_PHY, 5'd1, w, ok, drv);
    check("R8 status read-only", {16'd0, w}, 32'h0000_7849);

    // R10: out of range address
    doWrite(MY_PHY, 5'd20, 16'hBEEF);
    doRead(MY_PHY, 5'd20, w, ok, drv);
    check("R10 unmapped reads zero", {16'd0, w}, 32'd0);
    check("R10 unmapped still answers", {31'd0, ok}, 32'd1);

    // R6: other device address
    doWrite(5'h0D, 5'd3, 16'h1111);
    doRead(5'h0D, 5'd3, w, ok, drv);
    check("R6 mismatch no drive", {31'd0, drv}, 32'd0);
    doRead(MY_PHY, 5'd3, w, ok, drv);
    check("R6 mismatch no write", {16'd0, w}, {16'd0, expRead(5'd3)});

    // R7: bad start and illegal opcodes
    sendBit(1'b0); sendBit(1'b0);
    sendOnes(30);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0); sendBit(1'b0);
    sendOnes(28);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1); sendBit(1'b1);
    sendOnes(28);
    doRead(MY_PHY, 5'd3, w, ok, drv);
    check("R7 recovers after aborts", {31'd0, ok}, 32'd1);
    check("R7 aborts no side effect", {16'd0, w}, {16'd0, expRead(5'd3)});

    // R9: control bit 15 never reads back
    doWrite(MY_PHY, 5'd0, 16'h0042);
    modelWrite(5'd0, 16'h0042);
    doRead(MY_PHY, 5'd0, w, ok, drv);
    check("R9 control write", {16'd0, w}, {16'd0, expRead(5'd0)});

    // Random traffic against the model
    for (int it = 0; it < 80; it++) begin
      logic [4:0]  a;
      logic [15:0] d;
      a = 5'($urandom_range(0, 9));
      d = 16'($urandom);
      if (a == 5'd0) d[15] = 1'b0;
      if ($urandom_range(0, 1) == 0) begin
        doWrite(MY_PHY, a, d);
        modelWrite(a, d);
      end else begin
        doRead(MY_PHY, a, w, ok, drv);
        check("R3 R4 R10 random read", {16'd0, w}, {16'd0, expRead(a)});
        check("R3 random timing", {31'd0, ok}, 32'd1);
      end
      sendOnes(int'($urandom_range(0, 2)));
    end

    // R9: software reset
    doWrite(MY_PHY, 5'd3, 16'h5A5A);
    doWrite(MY_PHY, 5'd0, 16'h9234);
    modelWrite(5'd0, 16'h9234);
    doRead(MY_PHY, 5'd0, w, ok, drv);
    check("R9 needs preamble after soft reset", {31'd0, drv}, 32'd0);
    sendBit(1'b0);
    sendOnes(32);
    doRead(MY_PHY, 5'd0, w, ok, drv);
    check("R9 control back to default", {16'd0, w}, {16'd0, expRead(5'd0)});
    doRead(MY_PHY, 5'd3, w, ok, drv);
    check("R9 scratch cleared", {16'd0, w}, {16'd0, expRead(5'd3)});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule